// File: doc/BRIEF.md
# Sixteen-bit execution unit with flags, result steering and branch test

This block is the execution stage of a small 16-bit RISC core. Two operand registers feed four function units that work in parallel. One adds or subtracts with an optional carry-in. One computes a two-input logic function. Two produce one-bit shifts in each direction. A select input then steers one of six sources onto the result bus: the sum, the logic result, the right shift, the left shift, load data from the memory bus, or a return address. For byte loads the load data is taken from the addressed byte lane and the upper bits are cleared.

Zero, negative, carry and overflow flags are captured from the adder only on enabled cycles that the control marks as flag-setting. These are an add, a subtract or a compare. A compare is a subtract whose result is thrown away. A 4-bit condition input is tested against the captured flags to give the branch decision. Carry-in for the extended add and subtract, and the fill bit for the extended shifts, both come from the captured carry, so 32-bit values held in register pairs can be handled. All control inputs arrive already decoded.

Top module: `rx_exec_unit`

## Requirements
- R1: `logic_op` selects the logic result: 0 = A AND B, 1 = A OR B, 2 = A XOR B, 3 = A AND NOT B.
- R2: The sum is A + B + cin when `sub`=0 and A + ~B + cin when `sub`=1. Here cin is the carry flag when `use_carry`=1, and otherwise it equals `sub`.
- R3: On a clock edge with `en` and `flag_upd` both high, `flag_z` takes 1 exactly when the sum is all zero, and `flag_n` takes the sum's top bit.
- R4: On such an edge, `flag_c` takes the adder carry-out, so a subtract with no borrow sets it. `flag_v` takes the signed overflow of the operation.
- R5: Reset clears all four flags. On any edge where `en` and `flag_upd` are not both high, the flags keep their value.
- R6: The right shift is {fill, A[15:1]}. `fill_mode` 0 gives zero fill, 1 gives a copy of A[15], and 2 gives the carry flag.
- R7: The left shift is {A[14:0], fill}. The fill is the carry flag when `fill_mode`=2 and zero otherwise.
- R8: `res_sel` steers the result: 0 sum, 1 logic, 2 right shift, 3 left shift, 4 load data, 5 return address. Codes 6 and 7 give zero.
- R9: For load data with `ld_byte`=0 the result is the whole data bus. With `ld_byte`=1 the low 8 bits come from lane `ld_lane` (0 = bits 7:0, 1 = bits 15:8) and the upper bits are zero.
- R10: `br_cond` against the flags decides `br_taken`: 0 always, 1 never, 2 Z, 3 !Z, 4 C, 5 !C, 6 V, 7 !V, 8 N^V, 9 !(N^V), 10 (N^V)|Z, 11 !((N^V)|Z).
- R11: The unsigned codes decide `br_taken` as follows: 12 !C, 13 C, 14 !C|Z, 15 C&!Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Cycle enable for the flag register |
| a_op | input | 16 | A operand |
| b_op | input | 16 | B operand |
| sub | input | 1 | 1 = subtract B from A |
| use_carry | input | 1 | 1 = carry flag is the adder carry-in |
| flag_upd | input | 1 | Current operation sets the flags |
| logic_op | input | 2 | Logic function code |
| fill_mode | input | 2 | Shift fill selection |
| res_sel | input | 3 | Result source code |
| ld_data | input | 16 | Load data from the memory bus |
| ld_byte | input | 1 | Byte load |
| ld_lane | input | 1 | Byte lane of a byte load |
| ret_addr | input | 16 | Return address |
| br_cond | input | 4 | Branch condition code |
| result | output | 16 | Result bus |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| br_taken | output | 1 | Branch condition holds |

## Verification
The assertions assume the control holds `res_sel`, `fill_mode` and `br_cond` at defined codes and never leaves an operand X while `en` and `flag_upd` are high. Otherwise the captured flags and steered result would be undefined. The bench drives every input to a known value from reset onward and changes them only at the falling edge. It uses only the documented codes, plus two deliberately unused result codes that must read as zero. Carry-dependent paths are exercised only after a directed operation has put the carry flag into a known state.

// File: rtl/rx_exec_pkg.sv
package rx_exec_pkg;
   typedef enum logic [1:0] {LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_ANDN = 2'd3} logic_op_e;
   typedef enum logic [1:0] {FILL_ZERO = 2'd0, FILL_SIGN = 2'd1, FILL_CARRY = 2'd2, FILL_RSVD = 2'd3} fill_e;
   typedef enum logic [2:0] {
      SRC_SUM = 3'd0, SRC_LOGIC = 3'd1, SRC_SHR = 3'd2, SRC_SHL = 3'd3,
      SRC_LOAD = 3'd4, SRC_RET = 3'd5, SRC_NONE6 = 3'd6, SRC_NONE7 = 3'd7
   } src_e;
   typedef enum logic [3:0] {
      BC_ALWAYS = 4'd0, BC_NEVER = 4'd1, BC_EQ = 4'd2, BC_NE = 4'd3,
      BC_CS = 4'd4, BC_CC = 4'd5, BC_VS = 4'd6, BC_VC = 4'd7,
      BC_LT = 4'd8, BC_GE = 4'd9, BC_LE = 4'd10, BC_GT = 4'd11,
      BC_LTU = 4'd12, BC_GEU = 4'd13, BC_LEU = 4'd14, BC_GTU = 4'd15
   } cond_e;
endpackage

// File: rtl/rx_addsub.sv
module rx_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W-1:0] b_eff;
   logic [W:0]   wide;

   always_comb begin
      b_eff = sub ? ~b : b;
      wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
      sum   = wide[W-1:0];
      cout  = wide[W];
      ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
   end
endmodule

// File: rtl/rx_logic.sv
module rx_logic
   import rx_exec_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   op,
   output logic [W-1:0] y
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         unique case (logic_op_e'(op))
            LG_AND:  y[i] = a[i] & b[i];
            LG_OR:   y[i] = a[i] | b[i];
            LG_XOR:  y[i] = a[i] ^ b[i];
            default: y[i] = a[i] & ~b[i];
         endcase
      end
   end
endmodule

// File: rtl/rx_shift1.sv
module rx_shift1
   import rx_exec_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [1:0]   fill_mode,
   input  logic         carry,
   output logic [W-1:0] shr,
   output logic [W-1:0] shl
);
   logic fill_r, fill_l;

   always_comb begin
      unique case (fill_e'(fill_mode))
         FILL_SIGN:  fill_r = a[W-1];
         FILL_CARRY: fill_r = carry;
         default:    fill_r = 1'b0;
      endcase
      fill_l = (fill_e'(fill_mode) == FILL_CARRY) ? carry : 1'b0;
      shr    = {fill_r, a[W-1:1]};
      shl    = {a[W-2:0], fill_l};
   end
endmodule

// File: rtl/rx_flagbr.sv
module rx_flagbr
   import rx_exec_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] sum,
   input  logic         cout,
   input  logic         ovf,
   input  logic [3:0]   cond,
   output logic         z,
   output logic         n,
   output logic         c,
   output logic         v,
   output logic         taken
);
   logic lt_s, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z <= 1'b0;
         n <= 1'b0;
         c <= 1'b0;
         v <= 1'b0;
      end else if (load) begin
         z <= ~|sum;
         n <= sum[W-1];
         c <= cout;
         v <= ovf;
      end
   end

   always_comb begin
      lt_s = n ^ v;
      unique case (cond_e'({cond[3:1], 1'b0}))
         BC_ALWAYS: hit = 1'b1;
         BC_EQ:     hit = z;
         BC_CS:     hit = c;
         BC_VS:     hit = v;
         BC_LT:     hit = lt_s;
         BC_LE:     hit = lt_s | z;
         BC_LTU:    hit = ~c;
         default:   hit = ~c | z;
      endcase
      taken = hit ^ cond[0];
   end

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable({z, n, c, v}));
   assert_zero_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (z == ($past(sum) == '0)) && (n == $past(sum[W-1])));
   assert_carry_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (c == $past(cout)) && (v == $past(ovf)));
   assert_fixed_conds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cond == BC_ALWAYS || cond == BC_NEVER) |-> (taken == (cond == BC_ALWAYS)));
   assert_geu_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cond == BC_GEU) |-> (taken == c));
endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
   import rx_exec_pkg::*;
#(
   parameter int W       = 16,
   parameter int LANES   = W / 8,
   parameter int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [W-1:0]      a_op,
   input  logic [W-1:0]      b_op,
   input  logic              sub,
   input  logic              use_carry,
   input  logic              flag_upd,
   input  logic [1:0]        logic_op,
   input  logic [1:0]        fill_mode,
   input  logic [2:0]        res_sel,
   input  logic [W-1:0]      ld_data,
   input  logic              ld_byte,
   input  logic [LANE_W-1:0] ld_lane,
   input  logic [W-1:0]      ret_addr,
   input  logic [3:0]        br_cond,
   output logic [W-1:0]      result,
   output logic              flag_z,
   output logic              flag_n,
   output logic              flag_c,
   output logic              flag_v,
   output logic              br_taken
);
   if (W < 16 || (W % 8) != 0) begin : g_bad_width
      $error("rx_exec_unit: W must be a multiple of 8 and at least 16");
   end
   if (LANES != W / 8) begin : g_bad_lanes
      $error("rx_exec_unit: LANES must equal W/8");
   end

   logic [W-1:0] sum, lg, shr, shl, ld_word;
   logic         cout, ovf, cin;
   logic [7:0]   ld_b;

   assign cin = use_carry ? flag_c : sub;

   rx_addsub #(.W(W)) u_add (
      .a(a_op), .b(b_op), .sub(sub), .cin(cin),
      .sum(sum), .cout(cout), .ovf(ovf)
   );

   rx_logic #(.W(W)) u_logic (
      .a(a_op), .b(b_op), .op(logic_op), .y(lg)
   );

   rx_shift1 #(.W(W)) u_shift (
      .a(a_op), .fill_mode(fill_mode), .carry(flag_c), .shr(shr), .shl(shl)
   );

   rx_flagbr #(.W(W)) u_flags (
      .clk(clk), .rst_n(rst_n), .load(en & flag_upd),
      .sum(sum), .cout(cout), .ovf(ovf), .cond(br_cond),
      .z(flag_z), .n(flag_n), .c(flag_c), .v(flag_v), .taken(br_taken)
   );

   always_comb begin
      ld_b    = ld_data[8*ld_lane +: 8];
      ld_word = ld_byte ? {{(W-8){1'b0}}, ld_b} : ld_data;
      unique case (src_e'(res_sel))
         SRC_SUM:   result = sum;
         SRC_LOGIC: result = lg;
         SRC_SHR:   result = shr;
         SRC_SHL:   result = shl;
         SRC_LOAD:  result = ld_word;
         SRC_RET:   result = ret_addr;
         default:   result = '0;
      endcase
   end

   assert_shr_body_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == SRC_SHR) |-> (result[W-2:0] == a_op[W-1:1]));
   assert_shl_body_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == SRC_SHL) |-> (result[W-1:1] == a_op[W-2:0]));
   assert_ret_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == SRC_RET) |-> (result == ret_addr));
   assert_byte_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == SRC_LOAD && ld_byte) |-> (result[W-1:8] == '0));
endmodule

// File: tb/rx_exec_unit_test.sv
module rx_exec_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, sub = 1'b0, use_carry = 1'b0, flag_upd = 1'b0;
   logic [15:0] a_op = '0, b_op = '0, ld_data = '0, ret_addr = '0;
   logic [1:0]  logic_op = '0, fill_mode = '0;
   logic [2:0]  res_sel = '0;
   logic        ld_byte = 1'b0;
   logic [0:0]  ld_lane = '0;
   logic [3:0]  br_cond = '0;
   logic [15:0] result;
   logic        flag_z, flag_n, flag_c, flag_v, br_taken;
   int          nchk = 0, nfail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   rx_exec_unit uut (
      .clk(clk), .rst_n(rst_n), .en(en), .a_op(a_op), .b_op(b_op), .sub(sub),
      .use_carry(use_carry), .flag_upd(flag_upd), .logic_op(logic_op),
      .fill_mode(fill_mode), .res_sel(res_sel), .ld_data(ld_data),
      .ld_byte(ld_byte), .ld_lane(ld_lane), .ret_addr(ret_addr),
      .br_cond(br_cond), .result(result), .flag_z(flag_z), .flag_n(flag_n),
      .flag_c(flag_c), .flag_v(flag_v), .br_taken(br_taken)
   );

   typedef struct packed {
      logic [15:0] a, b;
      logic        sb;
      logic [1:0]  lop, fill;
      logic [2:0]  sel;
      logic [15:0] ld;
      logic        byt, lane;
      logic [15:0] ret, exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{16'h1234, 16'h0101, 1'b0, 2'd0, 2'd0, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h1335},
      '{16'h0005, 16'h0007, 1'b1, 2'd0, 2'd0, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0, 16'hFFFE},
      '{16'hFFFF, 16'h0001, 1'b0, 2'd0, 2'd0, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0000},
      '{16'hF0F0, 16'hFF00, 1'b0, 2'd0, 2'd0, 3'd1, 16'h0, 1'b0, 1'b0, 16'h0, 16'hF000},
      '{16'hF0F0, 16'hFF00, 1'b0, 2'd1, 2'd0, 3'd1, 16'h0, 1'b0, 1'b0, 16'h0, 16'hFFF0},
      '{16'hF0F0, 16'hFF00, 1'b0, 2'd2, 2'd0, 3'd1, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0FF0},
      '{16'hF0F0, 16'hFF00, 1'b0, 2'd3, 2'd0, 3'd1, 16'h0, 1'b0, 1'b0, 16'h0, 16'h00F0},
      '{16'h8003, 16'h0000, 1'b0, 2'd0, 2'd0, 3'd2, 16'h0, 1'b0, 1'b0, 16'h0, 16'h4001},
      '{16'h8003, 16'h0000, 1'b0, 2'd0, 2'd1, 3'd2, 16'h0, 1'b0, 1'b0, 16'h0, 16'hC001},
      '{16'h8003, 16'h0000, 1'b0, 2'd0, 2'd1, 3'd3, 16'h0, 1'b0, 1'b0, 16'h0, 16'h0006},
      '{16'h0000, 16'h0000, 1'b0, 2'd0, 2'd0, 3'd4, 16'hA55A, 1'b0, 1'b0, 16'h0, 16'hA55A},
      '{16'h0000, 16'h0000, 1'b0, 2'd0, 2'd0, 3'd4, 16'hA55A, 1'b1, 1'b0, 16'h0, 16'h005A},
      '{16'h0000, 16'h0000, 1'b0, 2'd0, 2'd0, 3'd4, 16'hA55A, 1'b1, 1'b1, 16'h0, 16'h00A5},
      '{16'h0000, 16'h0000, 1'b0, 2'd0, 2'd0, 3'd5, 16'h0, 1'b0, 1'b0, 16'h0C40, 16'h0C40},
      '{16'h1234, 16'h0101, 1'b0, 2'd0, 2'd0, 3'd6, 16'hA55A, 1'b0, 1'b0, 16'h0C40, 16'h0000}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic flags_chk(input string tag, input logic [3:0] exp);
      chk(tag, {12'h0, flag_z, flag_n, flag_c, flag_v}, {12'h0, exp});
   endtask

   task automatic arith(input logic [15:0] a, input logic [15:0] b, input logic s,
                        input logic e, input logic u);
      @(negedge clk);
      a_op = a; b_op = b; sub = s; use_carry = 1'b0; en = e; flag_upd = u; res_sel = 3'd0;
      @(negedge clk);
      en = 1'b0; flag_upd = 1'b0;
   endtask

   task automatic br_chk(input string tag, input logic [3:0] cond, input logic exp);
      br_cond = cond;
      #1;
      chk(tag, {15'h0, br_taken}, {15'h0, exp});
   endtask

   task automatic comb_chk(input string tag, input logic [15:0] a, input logic [15:0] b,
                           input logic s, input logic u, input logic [1:0] f,
                           input logic [2:0] sel, input logic [15:0] exp);
      @(negedge clk);
      a_op = a; b_op = b; sub = s; use_carry = u; fill_mode = f; res_sel = sel;
      #1;
      chk(tag, result, exp);
   endtask

   initial begin
      #200000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      flags_chk("R5 reset flags", 4'b0000);
      br_chk("R10 always", 4'd0, 1'b1);
      br_chk("R10 never", 4'd1, 1'b0);

      // R1 R2 R6 R8 R9: table of flag-independent result vectors
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         a_op = VECS[i].a; b_op = VECS[i].b; sub = VECS[i].sb; use_carry = 1'b0;
         logic_op = VECS[i].lop; fill_mode = VECS[i].fill; res_sel = VECS[i].sel;
         ld_data = VECS[i].ld; ld_byte = VECS[i].byt; ld_lane = VECS[i].lane;
         ret_addr = VECS[i].ret;
         #1;
         chk($sformatf("R1/R2/R6/R8/R9 vector %0d", i), result, VECS[i].exp);
      end

      // equal compare: Z=1 N=0 C=1 V=0
      arith(16'h0005, 16'h0005, 1'b1, 1'b1, 1'b1);
      flags_chk("R3/R4 cmp equal", 4'b1010);
      br_chk("R10 eq", 4'd2, 1'b1);
      br_chk("R10 ne", 4'd3, 1'b0);
      br_chk("R11 geu", 4'd13, 1'b1);
      br_chk("R11 leu", 4'd14, 1'b1);
      br_chk("R11 gtu", 4'd15, 1'b0);
      br_chk("R11 ltu", 4'd12, 1'b0);
      br_chk("R10 le", 4'd10, 1'b1);

      // 3 - 5: Z=0 N=1 C=0 V=0
      arith(16'h0003, 16'h0005, 1'b1, 1'b1, 1'b1);
      flags_chk("R3/R4 cmp less", 4'b0100);
      br_chk("R10 lt", 4'd8, 1'b1);
      br_chk("R10 gt", 4'd11, 1'b0);
      br_chk("R10 cc", 4'd5, 1'b1);
      br_chk("R11 ltu", 4'd12, 1'b1);

      // 0x8000 - 1: Z=0 N=0 C=1 V=1
      arith(16'h8000, 16'h0001, 1'b1, 1'b1, 1'b1);
      flags_chk("R4 cmp overflow", 4'b0011);
      br_chk("R10 vs", 4'd6, 1'b1);
      br_chk("R10 lt with overflow", 4'd8, 1'b1);
      br_chk("R10 ge with overflow", 4'd9, 1'b0);
      br_chk("R11 gtu", 4'd15, 1'b1);

      // 0x7FFF + 1: Z=0 N=1 C=0 V=1
      arith(16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b1);
      flags_chk("R4 add overflow", 4'b0101);
      br_chk("R10 vc", 4'd7, 1'b0);
      br_chk("R10 ge", 4'd9, 1'b1);

      // R5: no update without both enables
      arith(16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0);
      flags_chk("R5 hold flag_upd low", 4'b0101);
      arith(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1);
      flags_chk("R5 hold en low", 4'b0101);

      // set carry: 0xFFFF + 1 gives Z=1 C=1
      arith(16'hFFFF, 16'h0001, 1'b0, 1'b1, 1'b1);
      flags_chk("R3/R4 add carry", 4'b1010);
      br_chk("R10 cs", 4'd4, 1'b1);
      comb_chk("R2 add with carry set", 16'h0010, 16'h0020, 1'b0, 1'b1, 2'd0, 3'd0, 16'h0031);
      comb_chk("R2 sub with carry set", 16'h0010, 16'h0001, 1'b1, 1'b1, 2'd0, 3'd0, 16'h000F);
      comb_chk("R6 right through carry", 16'h0002, 16'h0000, 1'b0, 1'b0, 2'd2, 3'd2, 16'h8001);
      comb_chk("R7 left through carry", 16'h4000, 16'h0000, 1'b0, 1'b0, 2'd2, 3'd3, 16'h8001);
      comb_chk("R7 left sign mode zero fill", 16'h4000, 16'h0000, 1'b0, 1'b0, 2'd1, 3'd3, 16'h8000);

      // clear carry: 3 - 5
      arith(16'h0003, 16'h0005, 1'b1, 1'b1, 1'b1);
      comb_chk("R2 add with carry clear", 16'h0010, 16'h0020, 1'b0, 1'b1, 2'd0, 3'd0, 16'h0030);
      comb_chk("R2 sub with carry clear", 16'h0010, 16'h0001, 1'b1, 1'b1, 2'd0, 3'd0, 16'h000E);
      comb_chk("R6 right through carry clear", 16'h8002, 16'h0000, 1'b0, 1'b0, 2'd2, 3'd2, 16'h4001);
      comb_chk("R8 unused code 7", 16'h1234, 16'h1111, 1'b0, 1'b0, 2'd0, 3'd7, 16'h0000);

      // R5: reset clears flags that were set
      arith(16'hFFFF, 16'h0001, 1'b0, 1'b1, 1'b1);
      rst_n = 1'b0;
      #1;
      flags_chk("R5 reset clears", 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule